// File: doc/BRIEF.md
# Dual-Output Mode-Selected Clock Divider

This block turns one reference clock into two divided clocks, a primary and a secondary, each with its own power-of-two divide ratio (1, 2, 4 or 8) and its own output-enable flag. The ratios and enables come from three three-level control inputs: an enable control and two select controls. Each control arrives as a 2-bit level code. A sparse mode table maps the level combination to a ratio and an enable for each output. One mode turns off only the primary output.

The block runs on `clk`, which is taken to run at twice the reference rate. This lets a divide-by-one output still be a registered square wave. Both outputs are derived from one free-running count, so their rising edges line up. A new mode is applied only when the count wraps, so no pulse is ever cut short. A disabled output drops its enable flag and holds its clock low.

Top module: `clkdiv_dual_mode`

## Requirements
- R1: Each control input is decoded from its 2-bit code as follows: 2'b00 is low, 2'b01 is mid and 2'b11 is high. The unused code 2'b10 is read as low.
- R2: When the enable control is low, both `pri_oe` and `sec_oe` are 0 and both clocks are held low, whatever the select controls are.
- R3: With enable at mid, the (sel1, sel0) levels give these (primary, secondary) ratios: (low, mid) gives 1 and 1, (mid, high) gives 1 and 2, (low, high) gives 2 and 2, (low, low) gives 4 and 4, (high, low) gives 4 and 8, and (mid, mid) gives 8 and 1. Both outputs are enabled in all of these.
- R4: With enable at high, (low, low) gives 1 and 4, (low, high) gives 2 and 4, and (high, low) gives 8 and 4. The combination (high, high) disables only the primary output and runs the secondary at a ratio of 4.
- R5: Any enable and select combination that is not listed in R3 or R4 disables both outputs.
- R6: An enabled output at ratio R has a period of 2R `clk` cycles, high for R cycles and then low for R cycles. After reset is released, the output registered at edge n (n > 16) equals the inverse of bit log2(R) of ((n-1) mod 16). A disabled output stays low.
- R7: All enabled outputs rise in the same cycle, the one that follows the count wrap. Outputs with equal ratios are identical on every cycle.
- R8: The control inputs are sampled only at the edge where the 16-state count leaves its last state. Ratios and enables change only at that edge, and the clock outputs take their new form from the next edge on.
- R9: The synchronous active-high `rst` clears the count, drives both clocks low and deasserts both enables. After release, the first mode is loaded at edge 16 and the first high level appears at edge 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| en_code | input | 2 | Enable control level code |
| sel1_code | input | 2 | Select-1 control level code |
| sel0_code | input | 2 | Select-0 control level code |
| pri_clk | output | 1 | Primary divided clock |
| pri_oe | output | 1 | Primary output enable |
| sec_clk | output | 1 | Secondary divided clock |
| sec_oe | output | 1 | Secondary output enable |

## Verification
On every cycle, the assertions check that the shared count steps by one, that a disabled output stays low, that ratio and enable settings change only across a wrap, that an enable control at low switches both outputs off, and that two enabled outputs with equal ratios match. The bench's scenarios are needed to show the contents of the sparse mode table: every listed mode, the unlisted combinations, and the reading of the unused code as low. They also show the exact waveform phase after reset, and that a mode change made mid-period waits for the wrap.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam logic [1:0] LVL_LOW  = 2'b00;
   localparam logic [1:0] LVL_MID  = 2'b01;
   localparam logic [1:0] LVL_HIGH = 2'b11;
   localparam int LG_W = 3;

   typedef struct packed {
      logic            on;
      logic [LG_W-1:0] lg;
   } lane_cfg_t;

   // Map a raw code to a legal level; the unused code reads as low
   function automatic logic [1:0] norm_level(input logic [1:0] code);
      case (code)
         LVL_MID:  return LVL_MID;
         LVL_HIGH: return LVL_HIGH;
         default:  return LVL_LOW;
      endcase
   endfunction

   function automatic lane_cfg_t mk_cfg(input logic on, input int lg);
      lane_cfg_t c;
      c.on = on;
      c.lg = LG_W'(lg);
      return c;
   endfunction
endpackage

// File: rtl/clkdiv_mode_dec.sv
module clkdiv_mode_dec
   import clkdiv_pkg::*;
(
   input  logic [1:0] en_code,
   input  logic [1:0] sel1_code,
   input  logic [1:0] sel0_code,
   output lane_cfg_t  pri_cfg,
   output lane_cfg_t  sec_cfg
);
   logic [1:0] en_l, s1_l, s0_l;

   always_comb begin
      en_l = norm_level(en_code);
      s1_l = norm_level(sel1_code);
      s0_l = norm_level(sel0_code);
      pri_cfg = mk_cfg(1'b0, 0);
      sec_cfg = mk_cfg(1'b0, 0);
      case ({en_l, s1_l, s0_l})
         {LVL_MID,  LVL_LOW,  LVL_MID }: begin pri_cfg = mk_cfg(1'b1, 0); sec_cfg = mk_cfg(1'b1, 0); end
         {LVL_MID,  LVL_MID,  LVL_HIGH}: begin pri_cfg = mk_cfg(1'b1, 0); sec_cfg = mk_cfg(1'b1, 1); end
         {LVL_MID,  LVL_LOW,  LVL_HIGH}: begin pri_cfg = mk_cfg(1'b1, 1); sec_cfg = mk_cfg(1'b1, 1); end
         {LVL_MID,  LVL_LOW,  LVL_LOW }: begin pri_cfg = mk_cfg(1'b1, 2); sec_cfg = mk_cfg(1'b1, 2); end
         {LVL_MID,  LVL_HIGH, LVL_LOW }: begin pri_cfg = mk_cfg(1'b1, 2); sec_cfg = mk_cfg(1'b1, 3); end
         {LVL_MID,  LVL_MID,  LVL_MID }: begin pri_cfg = mk_cfg(1'b1, 3); sec_cfg = mk_cfg(1'b1, 0); end
         {LVL_HIGH, LVL_LOW,  LVL_LOW }: begin pri_cfg = mk_cfg(1'b1, 0); sec_cfg = mk_cfg(1'b1, 2); end
         {LVL_HIGH, LVL_LOW,  LVL_HIGH}: begin pri_cfg = mk_cfg(1'b1, 1); sec_cfg = mk_cfg(1'b1, 2); end
         {LVL_HIGH, LVL_HIGH, LVL_LOW }: begin pri_cfg = mk_cfg(1'b1, 3); sec_cfg = mk_cfg(1'b1, 2); end
         {LVL_HIGH, LVL_HIGH, LVL_HIGH}: begin pri_cfg = mk_cfg(1'b0, 0); sec_cfg = mk_cfg(1'b1, 2); end
         default: ;
      endcase
   end

   // R2
   always_comb begin
      if (norm_level(en_code) == LVL_LOW)
         en_low_off_chk: assert (!pri_cfg.on && !sec_cfg.on);
   end
endmodule

// File: rtl/clkdiv_cycle_cnt.sv
module clkdiv_cycle_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt_q,
   output logic             at_last
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("clkdiv_cycle_cnt: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign at_last = &cnt_q;

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/clkdiv_out_lane.sv
module clkdiv_out_lane
   import clkdiv_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             at_last,
   input  lane_cfg_t        cfg_i,
   output logic             oe_q,
   output logic [LG_W-1:0]  lg_q,
   output logic             clk_q
);
   logic [CNT_W-1:0] shifted;

   assign shifted = cnt_i >> lg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_q  <= 1'b0;
         lg_q  <= '0;
         clk_q <= 1'b0;
      end else begin
         clk_q <= oe_q & ~shifted[0];
         if (at_last) begin
            oe_q <= cfg_i.on;
            lg_q <= cfg_i.lg;
         end
      end
   end

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_i != '0) |-> ($stable(lg_q) && $stable(oe_q)));

   // R6
   off_low_chk: assert property (@(posedge clk) disable iff (rst)
      !oe_q |-> !clk_q);
endmodule

// File: rtl/clkdiv_dual_mode.sv
module clkdiv_dual_mode
   import clkdiv_pkg::*;
#(
   parameter int MAX_LOG2 = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] en_code,
   input  logic [1:0] sel1_code,
   input  logic [1:0] sel0_code,
   output logic       pri_clk,
   output logic       pri_oe,
   output logic       sec_clk,
   output logic       sec_oe
);
   localparam int CNT_W  = MAX_LOG2 + 1;
   localparam int NLANES = 2;

   generate
      if (MAX_LOG2 < 3 || MAX_LOG2 > 7) begin : g_bad_range
         $error("clkdiv_dual_mode: MAX_LOG2 must lie in 3..7");
      end
   endgenerate

   lane_cfg_t        cfg   [NLANES];
   logic             oe    [NLANES];
   logic             lclk  [NLANES];
   logic [LG_W-1:0]  lg    [NLANES];
   logic [CNT_W-1:0] cnt;
   logic             at_last;

   clkdiv_mode_dec u_dec (
      .en_code   (en_code),
      .sel1_code (sel1_code),
      .sel0_code (sel0_code),
      .pri_cfg   (cfg[0]),
      .sec_cfg   (cfg[1])
   );

   clkdiv_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .cnt_q   (cnt),
      .at_last (at_last)
   );

   generate
      for (genvar i = 0; i < NLANES; i++) begin : g_lane
         clkdiv_out_lane #(.CNT_W(CNT_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .cnt_i   (cnt),
            .at_last (at_last),
            .cfg_i   (cfg[i]),
            .oe_q    (oe[i]),
            .lg_q    (lg[i]),
            .clk_q   (lclk[i])
         );
      end
   endgenerate

   assign pri_clk = lclk[0];
   assign pri_oe  = oe[0];
   assign sec_clk = lclk[1];
   assign sec_oe  = oe[1];

   // R7
   equal_ratio_match_chk: assert property (@(posedge clk) disable iff (rst)
      (oe[0] && oe[1] && lg[0] == lg[1]) |-> (lclk[0] == lclk[1]));
endmodule

// File: tb/clkdiv_dual_mode_tb.sv
module clkdiv_dual_mode_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0] en_code = 2'b00, sel1_code = 2'b00, sel0_code = 2'b00;
   logic pri_clk, pri_oe, sec_clk, sec_oe;
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkdiv_dual_mode u_dut (
      .clk(clk), .rst(rst), .en_code(en_code), .sel1_code(sel1_code),
      .sel0_code(sel0_code), .pri_clk(pri_clk), .pri_oe(pri_oe),
      .sec_clk(sec_clk), .sec_oe(sec_oe)
   );

   // {en, sel1, sel0, pri_on, sec_on, pri_lg, sec_lg}
   localparam logic [11:0] VEC [NVEC] = '{
      {2'b00, 2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 2'd0},
      {2'b01, 2'b00, 2'b01, 1'b1, 1'b1, 2'd0, 2'd0},
      {2'b01, 2'b01, 2'b11, 1'b1, 1'b1, 2'd0, 2'd1},
      {2'b01, 2'b00, 2'b11, 1'b1, 1'b1, 2'd1, 2'd1},
      {2'b01, 2'b00, 2'b00, 1'b1, 1'b1, 2'd2, 2'd2},
      {2'b01, 2'b11, 2'b00, 1'b1, 1'b1, 2'd2, 2'd3},
      {2'b01, 2'b01, 2'b01, 1'b1, 1'b1, 2'd3, 2'd0},
      {2'b11, 2'b00, 2'b00, 1'b1, 1'b1, 2'd0, 2'd2},
      {2'b11, 2'b00, 2'b11, 1'b1, 1'b1, 2'd1, 2'd2},
      {2'b11, 2'b11, 2'b00, 1'b1, 1'b1, 2'd3, 2'd2},
      {2'b11, 2'b11, 2'b11, 1'b0, 1'b1, 2'd0, 2'd2},
      {2'b01, 2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 2'd0},
      {2'b11, 2'b01, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0},
      {2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0},
      {2'b01, 2'b10, 2'b01, 1'b1, 1'b1, 2'd0, 2'd0}
   };

   function automatic string vec_tag(input int i);
      if (i == 0)       return "R2";
      else if (i <= 6)  return "R3";
      else if (i <= 10) return "R4";
      else if (i <= 12) return "R5";
      else              return "R1";
   endfunction

   function automatic logic exp_wave(input logic on, input int lg, input int n);
      return on & ~((((n - 1) % 16) >> lg) & 1);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic start_mode(input logic [1:0] e, input logic [1:0] s1, input logic [1:0] s0);
      @(negedge clk);
      rst = 1'b1; en_code = e; sel1_code = s1; sel0_code = s0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R9", "reset outputs", {pri_clk, pri_oe, sec_clk, sec_oe}, 0);

      for (int i = 0; i < NVEC; i++) begin
         logic [11:0] v;
         int bad;
         v = VEC[i];
         start_mode(v[11:10], v[9:8], v[7:6]);
         repeat (15) @(posedge clk);
         @(negedge clk);
         // R9: nothing loaded before edge 16
         if (i == 1) check("R9", "enables before first load", {pri_oe, sec_oe}, 0);
         @(posedge clk);
         @(negedge clk);
         check(vec_tag(i), "enables", {pri_oe, sec_oe}, {v[5], v[4]});
         bad = 0;
         for (int n = 17; n <= 32; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (pri_clk !== exp_wave(v[5], int'(v[3:2]), n)) bad++;
            if (sec_clk !== exp_wave(v[4], int'(v[1:0]), n)) bad++;
         end
         check(vec_tag(i), "waveform mismatched cycles", bad, 0);
         check("R6", "waveform mismatched cycles", bad, 0);
      end

      // R7: ratio 8 and ratio 4 rise together at edge 17
      start_mode(2'b11, 2'b11, 2'b00);
      repeat (17) @(posedge clk);
      @(negedge clk);
      check("R7", "both rise at edge 17", {pri_clk, sec_clk}, 2'b11);

      // R7: equal ratios identical
      begin
         int diff;
         start_mode(2'b01, 2'b00, 2'b00);
         repeat (16) @(posedge clk);
         diff = 0;
         for (int n = 0; n < 32; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (pri_clk !== sec_clk) diff++;
         end
         check("R7", "equal ratio differing cycles", diff, 0);
      end

      // R8: change at edge 20 waits for the wrap at edge 32
      start_mode(2'b01, 2'b00, 2'b01);
      repeat (20) @(posedge clk);
      @(negedge clk);
      en_code = 2'b00;
      repeat (11) @(posedge clk);
      @(negedge clk);
      check("R8", "enables before wrap (edge 31)", {pri_oe, sec_oe}, 2'b11);
      check("R8", "primary still running at edge 31", pri_clk, exp_wave(1'b1, 0, 31));
      @(posedge clk);
      @(negedge clk);
      check("R8", "enables after wrap (edge 32)", {pri_oe, sec_oe}, 0);
      @(posedge clk);
      @(negedge clk);
      check("R8", "clocks low after wrap (edge 33)", {pri_clk, sec_clk}, 0);

      // R9: reset asserted mid-run clears everything at the next edge
      start_mode(2'b01, 2'b00, 2'b01);
      repeat (20) @(posedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R9", "outputs after mid-run reset", {pri_clk, pri_oe, sec_clk, sec_oe}, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule